// File: doc/BRIEF.md
# Multiprocessor Serial Receiver with Masked Address Filter

This block is the receive half of an asynchronous serial port that carries 11-bit frames: one low start bit, eight data bits sent least significant bit first, a ninth bit, and one high stop bit. A free-running tick at sixteen times the bit rate paces it. A falling edge on the line starts a frame. The receiver then splits each bit into sixteen tick slots and decides the bit value by vote.

When multiprocessor filtering is turned on, only address frames reach the output. An address frame is one whose ninth bit is 1. It must also match either the masked own address or the broadcast address that the same address and mask produce. All other frames are dropped without a trace. A sticky error flag records any frame whose stop bit arrives low, whether or not that frame is kept.

Kept frames leave through a valid/ready stream port. A held word stays stable until the consumer takes it. A frame that completes while the output is still full is discarded, because the receiver does not stall the serial line.

Top module: `mp_uart_rx`

## Requirements
- R1: During and after reset, `out_valid` and `frame_err` are 0.
- R2: With `mp_en` low, every received frame is offered on the stream port. The data is assembled LSB first into `out_data`, and the bit after the eighth data bit goes to `out_bit9`.
- R3: Each bit value is the majority of the line samples at ticks 7, 8 and 9 of that bit's 16 ticks, where tick 1 is the first tick after the falling edge that began the frame. A single wrong sample among the three does not change the bit.
- R4: If the start bit votes high, the frame is abandoned. Nothing is delivered and `frame_err` is unchanged. The next falling edge starts a fresh frame.
- R5: With `mp_en` high, a frame whose ninth bit is 0 is not delivered.
- R6: With `mp_en` high, a frame whose ninth bit is 1 and whose stop bit is high is delivered when `(data ^ slave_addr) & addr_mask == 0`. A 0 in the mask makes that bit a don't-care. For example, address A4h with mask FAh accepts A5h and A1h but not A6h. A frame with a low stop bit is never delivered in this mode.
- R7: With `mp_en` high, a frame whose ninth bit is 1 is also delivered when every bit that is 1 in `slave_addr | addr_mask` is also 1 in the data (the broadcast address).
- R8: A frame whose stop bit votes low sets `frame_err`. The flag stays set through later good frames until `fe_clr` is pulsed. A new error in the same cycle as `fe_clr` wins over the clear.
- R9: `frame_err` is set even when filtering discards the frame that carried the bad stop bit.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_bit9` hold. A frame that completes in that state is discarded.
- R11: While `rx_en` is low, falling edges do not start frames, so nothing is delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | One-cycle pulse at 16x the bit rate |
| rxd | input | 1 | Serial line, idle high, asynchronous to clk |
| rx_en | input | 1 | Allows new frames to start |
| mp_en | input | 1 | Turns on address filtering |
| slave_addr | input | 8 | Own address |
| addr_mask | input | 8 | 1 = address bit must match |
| fe_clr | input | 1 | Clears the framing-error flag |
| out_ready | input | 1 | Consumer accepts the held word |
| out_valid | output | 1 | A received word is held |
| out_data | output | 8 | Received data byte |
| out_bit9 | output | 1 | Received ninth bit |
| frame_err | output | 1 | Sticky framing-error flag |

## Verification
Plain frames with alternating, all-zero, all-one and mixed bytes show that bit order and ninth-bit placement are correct. Single-sample glitches at ticks 7 and 9, and a short low pulse on an idle line, separate a true majority vote from single-point sampling and show that the start check rejects noise. In filtered mode, the bench uses one address/mask pair with data frames, with address frames that hit only the masked pattern or only the broadcast pattern, and with frames that miss both. These cases tell the two match paths apart and show how the ninth bit gates delivery. Bad-stop frames, sent both kept and filtered, together with a held output under back-pressure, check the sticky error and the drop-when-full rule.

// File: rtl/mpu_rx_pkg.sv
package mpu_rx_pkg;
  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;
endpackage

// File: rtl/mpu_rx_sync.sv
// Line synchronizer with a falling-edge strobe on the synchronized value.
module mpu_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout,
  output logic fall
);
  logic [STAGES-1:0] pipe;
  logic              last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe <= '1;
      last <= 1'b1;
    end else begin
      pipe <= {pipe[STAGES-2:0], din};
      last <= pipe[STAGES-1];
    end
  end

  assign dout = pipe[STAGES-1];
  assign fall = last & ~dout;
endmodule

// File: rtl/mpu_rx_framer.sv
// Frame sequencer: start check, three-sample vote, data/ninth-bit shift, stop check.
module mpu_rx_framer
  import mpu_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rx_s,
  input  logic              fall,
  input  logic              rx_en,
  output logic              done,
  output logic [DATA_W-1:0] data,
  output logic              bit9,
  output logic              stop_ok
);
  localparam int PH_W = $clog2(OVS);
  localparam int BN_W = $clog2(DATA_W + 1);
  localparam logic [PH_W-1:0] S_A     = PH_W'(OVS/2 - 1);
  localparam logic [PH_W-1:0] S_B     = PH_W'(OVS/2);
  localparam logic [PH_W-1:0] S_C     = PH_W'(OVS/2 + 1);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(OVS - 1);
  localparam logic [BN_W-1:0] BN_LAST = BN_W'(DATA_W);

  rx_state_e         state;
  logic [PH_W-1:0]   phase, ph_nx;
  logic [BN_W-1:0]   bitn;
  logic [1:0]        ones;
  logic [DATA_W:0]   sreg;
  logic              vote;

  always_comb begin
    ph_nx = (phase == PH_LAST) ? '0 : phase + 1'b1;
    vote  = (ones + {1'b0, rx_s}) >= 2'd2;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= RX_IDLE;
      phase   <= '0;
      bitn    <= '0;
      ones    <= '0;
      sreg    <= '0;
      done    <= 1'b0;
      stop_ok <= 1'b1;
    end else begin
      done <= 1'b0;
      if (state == RX_IDLE) begin
        if (fall && rx_en) begin
          state <= RX_START;
          phase <= '0;
          ones  <= '0;
        end
      end else if (tick) begin
        phase <= ph_nx;
        if (ph_nx == S_A || ph_nx == S_B)
          ones <= ones + {1'b0, rx_s};
        if (ph_nx == S_C) begin
          case (state)
            RX_START: if (vote) state <= RX_IDLE;
            RX_DATA:  sreg <= {vote, sreg[DATA_W:1]};
            RX_STOP: begin
              done    <= 1'b1;
              stop_ok <= vote;
              state   <= RX_IDLE;
            end
            default: state <= RX_IDLE;
          endcase
        end
        if (phase == PH_LAST) begin
          ones <= '0;
          if (state == RX_START) begin
            state <= RX_DATA;
            bitn  <= '0;
          end else if (state == RX_DATA) begin
            if (bitn == BN_LAST) state <= RX_STOP;
            else                 bitn  <= bitn + 1'b1;
          end
        end
      end
    end
  end

  assign data = sreg[DATA_W-1:0];
  assign bit9 = sreg[DATA_W];
endmodule

// File: rtl/mpu_rx_addr_match.sv
// Masked own-address and broadcast comparison.
module mpu_rx_addr_match #(
  parameter int W = 8
) (
  input  logic [W-1:0] rx_byte,
  input  logic [W-1:0] own_addr,
  input  logic [W-1:0] care_mask,
  output logic         hit
);
  logic [W-1:0] bcast;
  logic         given_hit, bcast_hit;

  always_comb begin
    bcast     = own_addr | care_mask;
    given_hit = ((rx_byte ^ own_addr) & care_mask) == '0;
    bcast_hit = (bcast & ~rx_byte) == '0;
    hit       = given_hit | bcast_hit;
  end
endmodule

// File: rtl/mp_uart_rx.sv
module mp_uart_rx #(
  parameter int DATA_W      = 8,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              rxd,
  input  logic              rx_en,
  input  logic              mp_en,
  input  logic [DATA_W-1:0] slave_addr,
  input  logic [DATA_W-1:0] addr_mask,
  input  logic              fe_clr,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_bit9,
  output logic              frame_err
);
  logic              rx_s, rx_fall;
  logic              f_done, f_bit9, f_stop_ok;
  logic [DATA_W-1:0] f_data;
  logic              hit, accept, stop_bad;

  mpu_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rxd), .dout(rx_s), .fall(rx_fall)
  );

  mpu_rx_framer #(.DATA_W(DATA_W), .OVS(OVS)) u_framer (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .rx_s(rx_s), .fall(rx_fall),
    .rx_en(rx_en), .done(f_done), .data(f_data), .bit9(f_bit9),
    .stop_ok(f_stop_ok)
  );

  mpu_rx_addr_match #(.W(DATA_W)) u_match (
    .rx_byte(f_data), .own_addr(slave_addr), .care_mask(addr_mask), .hit(hit)
  );

  assign accept   = mp_en ? (f_bit9 & f_stop_ok & hit) : 1'b1;
  assign stop_bad = f_done & ~f_stop_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_bit9  <= 1'b0;
    end else if (f_done && accept && (!out_valid || out_ready)) begin
      out_valid <= 1'b1;
      out_data  <= f_data;
      out_bit9  <= f_bit9;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        frame_err <= 1'b0;
    else if (stop_bad) frame_err <= 1'b1;
    else if (fe_clr)   frame_err <= 1'b0;
  end
endmodule

// File: rtl/mp_uart_rx_chk.sv
module mp_uart_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mp_en,
  input logic [DATA_W-1:0] slave_addr,
  input logic [DATA_W-1:0] addr_mask,
  input logic              fe_clr,
  input logic              out_ready,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic              out_bit9,
  input logic              frame_err,
  input logic              stop_bad
);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_bit9));

  assert_fe_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err && !fe_clr |=> frame_err);

  assert_fe_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fe_clr && !stop_bad |=> !frame_err);

  assert_fe_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_bad |=> frame_err);

  assert_mp_ninth_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) && $past(mp_en) |-> out_bit9);

  // R6 masked address or R7 broadcast address
  assert_mp_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) && $past(mp_en) |->
      (((out_data ^ $past(slave_addr)) & $past(addr_mask)) == '0) ||
      ((($past(slave_addr) | $past(addr_mask)) & ~out_data) == '0));
endmodule

bind mp_uart_rx mp_uart_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mp_en(mp_en), .slave_addr(slave_addr),
  .addr_mask(addr_mask), .fe_clr(fe_clr), .out_ready(out_ready),
  .out_valid(out_valid), .out_data(out_data), .out_bit9(out_bit9),
  .frame_err(frame_err), .stop_bad(stop_bad)
);

// File: tb/test_mp_uart_rx.sv
module test_mp_uart_rx;
  localparam int CLK_P    = 10;
  localparam int TICK_DIV = 4;

  logic       clk = 1'b0, rst_n = 1'b0, tick16 = 1'b0, rxd = 1'b1;
  logic       rx_en = 1'b1, mp_en = 1'b0, fe_clr = 1'b0, out_ready = 1'b1;
  logic [7:0] slave_addr = 8'hA4, addr_mask = 8'hFA;
  logic       out_valid, out_bit9, frame_err;
  logic [7:0] out_data;

  int vecs = 0, miss = 0, hs = 0, tcnt = 0;
  logic [8:0] expq[$];

  mp_uart_rx i_mp_uart_rx (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd), .rx_en(rx_en),
    .mp_en(mp_en), .slave_addr(slave_addr), .addr_mask(addr_mask),
    .fe_clr(fe_clr), .out_ready(out_ready), .out_valid(out_valid),
    .out_data(out_data), .out_bit9(out_bit9), .frame_err(frame_err)
  );

  always #(CLK_P/2) clk = ~clk;

  always @(negedge clk) begin
    tick16 <= (tcnt == TICK_DIV-1);
    tcnt   <= (tcnt == TICK_DIV-1) ? 0 : tcnt + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    vecs++;
    if (!ok) begin
      miss++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      hs++;
      if (expq.size() == 0) chk(0, "R5 R6 R7 R11 unexpected word", {out_bit9, out_data}, 0);
      else begin
        logic [8:0] e;
        e = expq.pop_front();
        chk({out_bit9, out_data} == e, "R2 scoreboard", {out_bit9, out_data}, e);
      end
    end
  end

  task automatic wait_tick();
    do @(posedge clk); while (tick16 !== 1'b1);
    @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic b9, input logic stp,
                      input int gbit = -1, input int gslot = 0);
    logic [10:0] bits;
    bits = {stp, b9, d, 1'b0};
    wait_tick();
    for (int n = 0; n < 11; n++)
      for (int j = 1; j <= 16; j++) begin
        rxd = bits[n] ^ (n == gbit && j == gslot);
        wait_tick();
      end
    rxd = 1'b1;
    repeat (16) wait_tick();
  endtask

  function automatic bit model(input logic [7:0] d, input logic b9, input logic stp);
    logic [7:0] bc;
    bc = slave_addr | addr_mask;
    if (!mp_en) return 1'b1;
    return b9 && stp && ((((d ^ slave_addr) & addr_mask) == 8'h00) || ((bc & ~d) == 8'h00));
  endfunction

  task automatic xfer(input logic [7:0] d, input logic b9, input logic stp,
                      input int gbit = -1, input int gslot = 0);
    if (model(d, b9, stp)) expq.push_back({b9, d});
    send(d, b9, stp, gbit, gslot);
  endtask

  task automatic clear_fe();
    @(posedge clk); #1 fe_clr = 1'b1;
    @(posedge clk); #1 fe_clr = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    int h;
    repeat (5) @(negedge clk);
    chk(out_valid == 1'b0, "R1 valid in reset", out_valid, 0);
    chk(frame_err == 1'b0, "R1 error in reset", frame_err, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(out_valid == 1'b0, "R1 valid after reset", out_valid, 0);

    // R2 plain frames
    xfer(8'hA5, 0, 1); xfer(8'h3C, 1, 1); xfer(8'h00, 0, 1); xfer(8'hFF, 1, 1);
    chk(hs == 4, "R2 delivered count", hs, 4);

    // R3 single bad sample in each vote window
    xfer(8'h5A, 0, 1, 3, 7);
    xfer(8'hC3, 1, 1, 9, 9);
    xfer(8'h0F, 0, 1, 10, 8);
    chk(hs == 7, "R3 delivered count", hs, 7);
    chk(frame_err == 1'b0, "R3 stop glitch no error", frame_err, 0);

    // R4 short low pulse rejected
    h = hs;
    wait_tick(); rxd = 1'b0;
    repeat (3) wait_tick();
    rxd = 1'b1;
    repeat (40) wait_tick();
    chk(hs == h, "R4 no word on false start", hs, h);
    chk(frame_err == 1'b0, "R4 error untouched", frame_err, 0);
    xfer(8'h81, 1, 1);
    chk(hs == h + 1, "R4 recovery frame", hs, h + 1);

    // R5 R6 R7 filtered mode, address A4h mask FAh
    mp_en = 1'b1;
    h = hs;
    xfer(8'hA4, 0, 1);
    chk(hs == h, "R5 data frame ignored", hs, h);
    xfer(8'hA5, 1, 1); xfer(8'hA1, 1, 1);
    chk(hs == h + 2, "R6 masked matches", hs, h + 2);
    xfer(8'hA6, 1, 1);
    chk(hs == h + 2, "R6 mismatch dropped", hs, h + 2);
    xfer(8'hFF, 1, 1); xfer(8'hFE, 1, 1);
    chk(hs == h + 4, "R7 broadcast matches", hs, h + 4);
    xfer(8'hFD, 1, 1);
    chk(hs == h + 4, "R7 broadcast miss dropped", hs, h + 4);

    // R9 bad stop on filtered frames
    xfer(8'hA6, 1, 0);
    chk(frame_err == 1'b1, "R9 error on dropped frame", frame_err, 1);
    xfer(8'hA5, 1, 0);
    chk(hs == h + 4, "R6 bad stop not delivered", hs, h + 4);
    clear_fe();
    chk(frame_err == 1'b0, "R8 clear", frame_err, 0);

    // R8 sticky error in plain mode
    mp_en = 1'b0;
    xfer(8'h33, 0, 0);
    chk(frame_err == 1'b1, "R8 set by low stop", frame_err, 1);
    xfer(8'h44, 1, 1);
    chk(frame_err == 1'b1, "R8 sticky over good frame", frame_err, 1);
    clear_fe();
    chk(frame_err == 1'b0, "R8 cleared", frame_err, 0);

    // R10 back-pressure
    h = hs;
    @(posedge clk); #1 out_ready = 1'b0;
    xfer(8'h12, 0, 1);
    chk(out_valid == 1'b1, "R10 valid held", out_valid, 1);
    send(8'h34, 1, 1);
    chk(out_data == 8'h12, "R10 data held", out_data, 8'h12);
    chk(out_bit9 == 1'b0, "R10 ninth held", out_bit9, 0);
    @(posedge clk); #1 out_ready = 1'b1;
    repeat (4) @(negedge clk);
    chk(hs == h + 1, "R10 one word after release", hs, h + 1);
    chk(out_valid == 1'b0, "R10 overflow frame dropped", out_valid, 0);

    // R11 receiver disabled
    h = hs;
    rx_en = 1'b0;
    send(8'h55, 1, 1);
    chk(hs == h, "R11 nothing while disabled", hs, h);
    rx_en = 1'b1;
    xfer(8'h66, 0, 1);
    chk(hs == h + 1, "R11 enabled again", hs, h + 1);

    chk(expq.size() == 0, "R2 leftover expected words", expq.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    vecs++; miss++;
    $display("FAIL watchdog R2 actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end
endmodule